// File: doc/BRIEF.md
# Transmit Descriptor-Ring DMA Engine

This block feeds a transmit FIFO with outgoing packets held in host memory. Software lays out a ring of three-word descriptors and points the engine at the first one. Each descriptor holds a buffer start address, a size word and a pointer to the next descriptor. The engine reads each descriptor in turn. It waits until the FIFO can take a full-size packet, copies the packet words into the FIFO and marks the descriptor as consumed by setting the top bit of its size word. It then follows the next pointer.

The ring ends when the engine fetches a descriptor whose size word already has bit 31 set, meaning nothing is queued there. That is an underrun. A bus error also ends the ring. On either stop the engine clears its own enable. It stays idle until software writes the descriptor pointer and sets enable again. Sticky status flags, an 8-bit sent-packet counter and a masked, level interrupt let software follow progress.

Register map (word index on `reg_addr`): 0 control (bit 0 enable), 1 descriptor pointer (word aligned, low two bits read as zero), 2 status (bit 0 packet sent, bit 1 underrun, bit 2 bus error, bits [23:16] sent counter), 3 interrupt (bits [2:0] mask with the same bit positions as the status flags, bits [10:8] pending = flag AND mask, read only).

Top module: `txring_dma`

## Requirements
- R1: After reset, every register reads zero, and `irq`, `mem_req` and `fifo_wr` are low.
- R2: The descriptor at address D is read as three word reads in this order: D, D+4, D+8. Each access keeps `mem_req`, `mem_addr` and `mem_we` steady until a cycle with `mem_ready` or `mem_err` high.
- R3: If the size word (D+4) has bit 31 set when it is read, the engine stops. It sets status bit 1, clears enable, and issues no further access for that descriptor.
- R4: No packet data is read while `fifo_room` is low. Copying starts only in a cycle where `fifo_room` is high.
- R5: A packet of L bytes, where L is bits [11:0] of the size word, is copied as ceil(L/4) word reads from the buffer address upward. On the final word `fifo_last` is 1 and `fifo_bytes` is L mod 4, or 4 when that remainder is 0. All other words carry `fifo_bytes` = 4. When L = 0, no data is read.
- R6: After the packet is copied, the size word at D+4 is written back with bit 31 set and bits [30:0] unchanged.
- R7: Each write-back that completes without error sets status bit 0 and adds one to the counter in status bits [23:16]. The counter wraps from 255 to 0.
- R8: The next descriptor comes from the word at D+8. The descriptor pointer register follows the ring, so after a stop it holds the address of the descriptor that caused the stop.
- R9: A response with `mem_err` high stops the engine. It sets status bit 2 and clears enable. That word is not written to the FIFO, and an interrupted descriptor is not written back.
- R10: `irq` goes high one cycle after any status flag whose mask bit is set. Bits [10:8] of register 3 show the pending causes.
- R11: Writing 1 to a status flag bit clears that flag. Writing 0 leaves the flag unchanged.
- R12: Once stopped, the engine makes no memory request until software sets enable again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ready` |
| mem_ready | input | 1 | Access completes this cycle |
| mem_err | input | 1 | Access fails this cycle |
| fifo_room | input | 1 | FIFO can accept a maximum-size packet |
| fifo_wr | output | 1 | FIFO word write strobe |
| fifo_data | output | 32 | FIFO write word |
| fifo_last | output | 1 | Word is the last of its packet |
| fifo_bytes | output | 3 | Valid bytes in the word, 1 to 4 |
| irq | output | 1 | Interrupt request, level |

## Verification
The bench builds the engine with its default parameters: 32-bit addresses, a 12-bit length field, an 8-bit sent counter and a registered interrupt. With an 8-bit counter, a few hundred short packets are enough to push the counter past 255. Directed runs cover an empty terminating descriptor, a zero-length packet, a held-low FIFO room signal and an error on a mid-packet data word. A ring with randomly placed, out-of-order descriptors, random lengths, random memory stalls and random FIFO room checks the copied word stream and the byte counts on final words.

// File: rtl/txring_pkg.sv
package txring_pkg;

   typedef enum logic [2:0] {
      S_IDLE,
      S_DADDR,
      S_DSIZE,
      S_DNEXT,
      S_ROOM,
      S_DATA,
      S_WBACK
   } seq_st_t;

   localparam logic [1:0] RA_CTRL = 2'd0;
   localparam logic [1:0] RA_DESC = 2'd1;
   localparam logic [1:0] RA_STAT = 2'd2;
   localparam logic [1:0] RA_IRQ  = 2'd3;

   localparam int FL_SENT = 0;
   localparam int FL_UNDR = 1;
   localparam int FL_BERR = 2;
   localparam int NFLAGS  = 3;

   localparam int EMPTY_BIT = 31;
   localparam int CNT_LSB   = 16;

endpackage

// File: rtl/txring_lenmath.sv
module txring_lenmath #(
   parameter int LEN_W = 12
) (
   input  logic [LEN_W-1:0] len_i,
   output logic [LEN_W-2:0] nwords_o,
   output logic [2:0]       tail_o
);

   localparam int WC_W = LEN_W - 1;

   logic partial;

   assign partial  = |len_i[1:0];
   assign nwords_o = {1'b0, len_i[LEN_W-1:2]} + WC_W'(partial);
   assign tail_o   = partial ? {1'b0, len_i[1:0]} : 3'd4;

endmodule

// File: rtl/txring_seq.sv
module txring_seq
   import txring_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int LEN_W  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic [ADDR_W-1:0] desc_ptr_i,
   input  logic              fifo_room_i,
   output logic              mem_req_o,
   output logic              mem_we_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [31:0]       mem_wdata_o,
   input  logic [31:0]       mem_rdata_i,
   input  logic              mem_ready_i,
   input  logic              mem_err_i,
   output logic              fifo_wr_o,
   output logic [31:0]       fifo_data_o,
   output logic              fifo_last_o,
   output logic [2:0]        fifo_bytes_o,
   output logic              ev_done_o,
   output logic              ev_undr_o,
   output logic              ev_berr_o,
   output logic [ADDR_W-1:0] nxt_desc_o
);

   localparam int WC_W = LEN_W - 1;
   localparam logic [ADDR_W-1:0] OFS_SIZE = ADDR_W'(4);
   localparam logic [ADDR_W-1:0] OFS_NEXT = ADDR_W'(8);
   localparam logic [ADDR_W-1:0] STEP     = ADDR_W'(4);
   localparam logic [WC_W-1:0]   ONE_W    = WC_W'(1);

   seq_st_t state_q, state_d;
   logic [ADDR_W-1:0] cur_q, buf_q, next_q;
   logic [31:0]       size_q;
   logic [WC_W-1:0]   wleft_q;
   logic [WC_W-1:0]   nwords;
   logic [2:0]        tail;
   logic              accept, good;
   logic [ADDR_W-1:0] rd_ptr;

   txring_lenmath #(.LEN_W(LEN_W)) len_i (
      .len_i    (size_q[LEN_W-1:0]),
      .nwords_o (nwords),
      .tail_o   (tail)
   );

   assign rd_ptr = {mem_rdata_i[ADDR_W-1:2], 2'b00};

   always_comb begin
      mem_req_o  = (state_q == S_DADDR) || (state_q == S_DSIZE) || (state_q == S_DNEXT)
                || (state_q == S_DATA)  || (state_q == S_WBACK);
      mem_we_o   = (state_q == S_WBACK);
      mem_addr_o = cur_q;
      case (state_q)
         S_DSIZE, S_WBACK: mem_addr_o = cur_q + OFS_SIZE;
         S_DNEXT:          mem_addr_o = cur_q + OFS_NEXT;
         S_DATA:           mem_addr_o = buf_q;
         default:          mem_addr_o = cur_q;
      endcase
   end

   assign mem_wdata_o  = size_q | (32'd1 << EMPTY_BIT);
   assign accept       = mem_req_o && (mem_ready_i || mem_err_i);
   assign good         = accept && !mem_err_i;
   assign ev_berr_o    = mem_req_o && mem_err_i;
   assign ev_undr_o    = good && (state_q == S_DSIZE) && mem_rdata_i[EMPTY_BIT];
   assign ev_done_o    = good && (state_q == S_WBACK);
   assign nxt_desc_o   = next_q;
   assign fifo_wr_o    = (state_q == S_DATA) && mem_ready_i && !mem_err_i;
   assign fifo_data_o  = mem_rdata_i;
   assign fifo_last_o  = (state_q == S_DATA) && (wleft_q == ONE_W);
   assign fifo_bytes_o = fifo_last_o ? tail : 3'd4;

   always_comb begin
      state_d = state_q;
      case (state_q)
         S_IDLE:  if (en_i) state_d = S_DADDR;
         S_DADDR: if (accept) state_d = mem_err_i ? S_IDLE : S_DSIZE;
         S_DSIZE: if (accept) state_d = (mem_err_i || mem_rdata_i[EMPTY_BIT]) ? S_IDLE : S_DNEXT;
         S_DNEXT: if (accept) state_d = mem_err_i ? S_IDLE : S_ROOM;
         S_ROOM:  if (fifo_room_i) state_d = (wleft_q == '0) ? S_WBACK : S_DATA;
         S_DATA:  if (accept) state_d = mem_err_i ? S_IDLE :
                                        ((wleft_q == ONE_W) ? S_WBACK : S_DATA);
         S_WBACK: if (accept) state_d = mem_err_i ? S_IDLE : (en_i ? S_DADDR : S_IDLE);
         default: state_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         cur_q   <= '0;
         buf_q   <= '0;
         next_q  <= '0;
         size_q  <= '0;
         wleft_q <= '0;
      end else begin
         state_q <= state_d;
         case (state_q)
            S_IDLE:  if (en_i) cur_q <= desc_ptr_i;
            S_DADDR: if (good) buf_q <= rd_ptr;
            S_DSIZE: if (good) size_q <= mem_rdata_i;
            S_DNEXT: if (good) begin
               next_q  <= rd_ptr;
               wleft_q <= nwords;
            end
            S_DATA:  if (good) begin
               buf_q   <= buf_q + STEP;
               wleft_q <= wleft_q - ONE_W;
            end
            S_WBACK: if (good) cur_q <= next_q;
            default: ;
         endcase
      end
   end

   // R2
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && !mem_ready_i && !mem_err_i) |=>
         (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

   // R4
   room_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_ROOM && !fifo_room_i) |=> (state_q == S_ROOM && !fifo_wr_o));

   // R6
   wback_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && mem_we_o) |-> mem_wdata_o[EMPTY_BIT]);

   // R5
   last_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_wr_o && fifo_last_o) |=> !fifo_wr_o);

endmodule

// File: rtl/txring_regs.sv
module txring_regs
   import txring_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int CNT_W   = 8,
   parameter bit IRQ_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_i,
   input  logic [1:0]        reg_addr_i,
   input  logic [31:0]       reg_wdata_i,
   output logic [31:0]       reg_rdata_o,
   input  logic              ev_done_i,
   input  logic              ev_undr_i,
   input  logic              ev_berr_i,
   input  logic [ADDR_W-1:0] nxt_desc_i,
   output logic              en_o,
   output logic [ADDR_W-1:0] desc_o,
   output logic              irq_o
);

   logic              en_q;
   logic [ADDR_W-1:0] desc_q;
   logic [NFLAGS-1:0] flags_q, flags_d, mask_q, pend;
   logic [CNT_W-1:0]  cnt_q;
   logic              wr_ctrl, wr_desc, wr_stat, wr_irq;

   assign wr_ctrl = reg_wr_i && (reg_addr_i == RA_CTRL);
   assign wr_desc = reg_wr_i && (reg_addr_i == RA_DESC);
   assign wr_stat = reg_wr_i && (reg_addr_i == RA_STAT);
   assign wr_irq  = reg_wr_i && (reg_addr_i == RA_IRQ);
   assign pend    = flags_q & mask_q;

   always_comb begin
      flags_d = flags_q;
      if (wr_stat) flags_d = flags_d & ~reg_wdata_i[NFLAGS-1:0];
      if (ev_done_i) flags_d[FL_SENT] = 1'b1;
      if (ev_undr_i) flags_d[FL_UNDR] = 1'b1;
      if (ev_berr_i) flags_d[FL_BERR] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         desc_q  <= '0;
         flags_q <= '0;
         mask_q  <= '0;
         cnt_q   <= '0;
      end else begin
         flags_q <= flags_d;
         if (ev_undr_i || ev_berr_i) en_q <= 1'b0;
         else if (wr_ctrl)           en_q <= reg_wdata_i[0];
         if (ev_done_i)    desc_q <= nxt_desc_i;
         else if (wr_desc) desc_q <= {reg_wdata_i[ADDR_W-1:2], 2'b00};
         if (wr_irq)    mask_q <= reg_wdata_i[NFLAGS-1:0];
         if (ev_done_i) cnt_q  <= cnt_q + CNT_W'(1);
      end
   end

   always_comb begin
      reg_rdata_o = '0;
      case (reg_addr_i)
         RA_CTRL: reg_rdata_o[0] = en_q;
         RA_DESC: reg_rdata_o[ADDR_W-1:0] = desc_q;
         RA_STAT: begin
            reg_rdata_o[NFLAGS-1:0]       = flags_q;
            reg_rdata_o[CNT_LSB +: CNT_W] = cnt_q;
         end
         default: begin
            reg_rdata_o[NFLAGS-1:0] = mask_q;
            reg_rdata_o[8 +: NFLAGS] = pend;
         end
      endcase
   end

   generate
      if (IRQ_REG) begin : g_irq_ff
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= |pend;
         end
         assign irq_o = irq_q;
      end else begin : g_irq_comb
         assign irq_o = |pend;
      end
   endgenerate

   assign en_o   = en_q;
   assign desc_o = desc_q;

   // R9
   berr_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_berr_i |=> (!en_q && flags_q[FL_BERR]));

   // R3
   undr_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_undr_i |=> (!en_q && flags_q[FL_UNDR]));

   // R7
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_done_i |=> (cnt_q == $past(cnt_q) + CNT_W'(1) && flags_q[FL_SENT]));

   // R11
   w1c_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!reg_wr_i && !ev_done_i && !ev_undr_i && !ev_berr_i) |=> $stable(flags_q));

endmodule

// File: rtl/txring_dma.sv
module txring_dma #(
   parameter int ADDR_W  = 32,
   parameter int LEN_W   = 12,
   parameter int CNT_W   = 8,
   parameter bit IRQ_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [1:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [31:0]       mem_wdata,
   input  logic [31:0]       mem_rdata,
   input  logic              mem_ready,
   input  logic              mem_err,
   input  logic              fifo_room,
   output logic              fifo_wr,
   output logic [31:0]       fifo_data,
   output logic              fifo_last,
   output logic [2:0]        fifo_bytes,
   output logic              irq
);

   generate
      if (ADDR_W < 8 || ADDR_W > 32) begin : g_bad_addr
         $error("txring_dma: ADDR_W must lie in 8..32");
      end
      if (LEN_W < 3 || LEN_W > 31) begin : g_bad_len
         $error("txring_dma: LEN_W must lie in 3..31");
      end
      if (CNT_W < 1 || CNT_W > 8) begin : g_bad_cnt
         $error("txring_dma: CNT_W must lie in 1..8");
      end
   endgenerate

   logic              en, ev_done, ev_undr, ev_berr;
   logic [ADDR_W-1:0] desc_ptr, nxt_desc;

   txring_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .IRQ_REG(IRQ_REG)) regs_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .reg_wr_i    (reg_wr),
      .reg_addr_i  (reg_addr),
      .reg_wdata_i (reg_wdata),
      .reg_rdata_o (reg_rdata),
      .ev_done_i   (ev_done),
      .ev_undr_i   (ev_undr),
      .ev_berr_i   (ev_berr),
      .nxt_desc_i  (nxt_desc),
      .en_o        (en),
      .desc_o      (desc_ptr),
      .irq_o       (irq)
   );

   txring_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) seq_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .en_i         (en),
      .desc_ptr_i   (desc_ptr),
      .fifo_room_i  (fifo_room),
      .mem_req_o    (mem_req),
      .mem_we_o     (mem_we),
      .mem_addr_o   (mem_addr),
      .mem_wdata_o  (mem_wdata),
      .mem_rdata_i  (mem_rdata),
      .mem_ready_i  (mem_ready),
      .mem_err_i    (mem_err),
      .fifo_wr_o    (fifo_wr),
      .fifo_data_o  (fifo_data),
      .fifo_last_o  (fifo_last),
      .fifo_bytes_o (fifo_bytes),
      .ev_done_o    (ev_done),
      .ev_undr_o    (ev_undr),
      .ev_berr_o    (ev_berr),
      .nxt_desc_o   (nxt_desc)
   );

   // R12
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !mem_req) |=> !mem_req);

endmodule

// File: tb/txring_dma_tb_top.sv
`timescale 1ns/1ps
module txring_dma_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;
   logic        mem_ready = 1'b0, mem_err = 1'b0, fifo_room = 1'b0;
   logic        fifo_wr, fifo_last, irq;
   logic [31:0] fifo_data;
   logic [2:0]  fifo_bytes;

   txring_dma dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .mem_ready(mem_ready), .mem_err(mem_err),
      .fifo_room(fifo_room), .fifo_wr(fifo_wr), .fifo_data(fifo_data),
      .fifo_last(fifo_last), .fifo_bytes(fifo_bytes), .irq(irq)
   );

   always #4 clk = ~clk;

   logic [31:0] mem [0:1023];
   assign mem_rdata = mem[mem_addr[11:2]];

   int checks = 0, fails = 0;
   int room_mode = 0;
   bit err_on = 1'b0;
   logic [31:0] err_addr = '0;

   logic [31:0] fdat [0:4095];
   bit          flst [0:4095];
   logic [2:0]  fbyt [0:4095];
   int          fcnt = 0;
   logic [31:0] edat [0:4095];
   bit          elst [0:4095];
   logic [2:0]  ebyt [0:4095];
   int          ecnt = 0;
   logic [31:0] laddr [0:4095];
   bit          lwe [0:4095];
   int          lcnt = 0;
   int          exp_cnt = 0;

   always @(posedge clk) begin
      if (rst_n && mem_req && (mem_ready || mem_err)) begin
         if (lcnt < 4096) begin
            laddr[lcnt] = mem_addr;
            lwe[lcnt]   = mem_we;
         end
         lcnt = lcnt + 1;
         if (mem_we && !mem_err) mem[mem_addr[11:2]] = mem_wdata;
      end
      if (rst_n && fifo_wr) begin
         if (fcnt < 4096) begin
            fdat[fcnt] = fifo_data;
            flst[fcnt] = fifo_last;
            fbyt[fcnt] = fifo_bytes;
         end
         fcnt = fcnt + 1;
      end
   end

   always @(negedge clk) begin
      mem_ready <= mem_req && ($urandom_range(0, 3) != 0);
      mem_err   <= mem_req && err_on && (mem_addr == err_addr);
      case (room_mode)
         0: fifo_room <= 1'b0;
         1: fifo_room <= 1'b1;
         default: fifo_room <= ($urandom_range(0, 2) != 0);
      endcase
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   function automatic int words_of(input int len);
      return (len + 3) / 4;
   endfunction

   function automatic logic [2:0] tail_of(input int len);
      return (len % 4 == 0) ? 3'd4 : 3'(len % 4);
   endfunction

   task automatic put_desc(input int a, input logic [31:0] b, input logic [31:0] sz, input logic [31:0] nx);
      mem[a/4] = b; mem[a/4+1] = sz; mem[a/4+2] = nx;
   endtask

   task automatic expect_pkt(input int b, input int len, input int nmax);
      for (int w = 0; w < words_of(len) && w < nmax; w++) begin
         edat[ecnt] = mem[b/4 + w];
         elst[ecnt] = (w == words_of(len) - 1);
         ebyt[ecnt] = (w == words_of(len) - 1) ? tail_of(len) : 3'd4;
         ecnt++;
      end
   endtask

   task automatic clear_logs();
      fcnt = 0; ecnt = 0; lcnt = 0;
   endtask

   task automatic wait_stop();
      logic [31:0] v;
      for (int i = 0; i < 5000; i++) begin
         reg_read(2'd0, v);
         if (v[0] == 1'b0) break;
      end
   endtask

   task automatic cmp_stream(input string tag);
      int bad = 0;
      chk(fcnt == ecnt, {tag, " word count"}, fcnt, ecnt);
      for (int i = 0; i < ecnt && i < fcnt; i++)
         if (fdat[i] !== edat[i] || flst[i] !== elst[i] || fbyt[i] !== ebyt[i]) bad++;
      chk(bad == 0, {tag, " stream words"}, bad, 0);
   endtask

   initial begin
      #(8 * 150000);
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      logic [31:0] v;
      int base_l, seed;
      int lens [0:5];
      int dadr [0:6];
      seed = $urandom(32'd20240611);
      for (int i = 0; i < 1024; i++) mem[i] = (i * 32'h9E3779B1) ^ 32'h5A5A0000;

      // R1 reset state
      repeat (3) @(negedge clk);
      chk(mem_req == 1'b0 && fifo_wr == 1'b0 && irq == 1'b0, "R1 outputs in reset", {mem_req, fifo_wr, irq}, 0);
      rst_n = 1'b1;
      for (int a = 0; a < 4; a++) begin
         reg_read(2'(a), v);
         chk(v == 32'd0, "R1 register after reset", v, 0);
      end

      // Directed ring: 5, 8, 0 bytes then an empty descriptor
      put_desc(32'h100, 32'h400, 32'h0123_4005, 32'h10C);
      put_desc(32'h10C, 32'h440, 32'h0000_0008, 32'h118);
      put_desc(32'h118, 32'h480, 32'h0040_0000, 32'h124);
      put_desc(32'h124, 32'h4C0, 32'h8000_0004, 32'h100);
      expect_pkt(32'h400, 5, 99);
      expect_pkt(32'h440, 8, 99);
      room_mode = 0;
      reg_write(2'd3, 32'h2);
      reg_write(2'd1, 32'h100);
      reg_write(2'd0, 32'h1);
      repeat (40) @(negedge clk);
      chk(fcnt == 0, "R4 no copy while room low", fcnt, 0);
      chk(lcnt == 3, "R4 engine holds after descriptor fetch", lcnt, 3);
      chk(laddr[0] == 32'h100 && laddr[1] == 32'h104 && laddr[2] == 32'h108 && !lwe[0],
          "R2 descriptor read order", laddr[1], 32'h104);
      room_mode = 1;
      wait_stop();
      exp_cnt += 3;
      cmp_stream("R5 directed");
      chk(mem[32'h104/4] == 32'h8123_4005, "R6 write-back keeps low bits", mem[32'h104/4], 32'h8123_4005);
      chk(mem[32'h11C/4] == 32'h8040_0000, "R5 zero-length packet completed", mem[32'h11C/4], 32'h8040_0000);
      chk(lcnt >= 2 && laddr[lcnt-1] == 32'h128 && laddr[lcnt-2] == 32'h124,
          "R3 stop after empty size word", laddr[lcnt-1], 32'h128);
      reg_read(2'd2, v);
      chk(v == ((exp_cnt % 256) << 16 | 32'h3), "R7 R3 status after ring", v, (exp_cnt % 256) << 16 | 32'h3);
      reg_read(2'd1, v);
      chk(v == 32'h124, "R8 pointer left at empty descriptor", v, 32'h124);
      reg_read(2'd3, v);
      chk(v == 32'h202 && irq == 1'b1, "R10 underrun pending and irq", v, 32'h202);

      // R12 stays idle
      base_l = lcnt;
      repeat (20) @(negedge clk);
      chk(lcnt == base_l && mem_req == 1'b0, "R12 idle after stop", lcnt, base_l);

      // R11 write-one-to-clear
      reg_write(2'd2, 32'h0);
      reg_read(2'd2, v);
      chk(v[2:0] == 3'b011, "R11 writing zero keeps flags", v[2:0], 3'b011);
      reg_write(2'd2, 32'h2);
      repeat (2) @(negedge clk);
      reg_read(2'd2, v);
      chk(v[2:0] == 3'b001, "R11 clear underrun only", v[2:0], 3'b001);
      chk(irq == 1'b0, "R10 masked sent flag gives no irq", irq, 0);

      // Random ring, descriptors out of address order
      reg_write(2'd2, 32'h7);
      clear_logs();
      for (int k = 0; k < 6; k++) begin
         lens[k] = $urandom_range(0, 40);
         dadr[k] = 32'h200 + ((k * 5) % 6) * 16;
      end
      dadr[6] = 32'h300;
      for (int k = 0; k < 6; k++) begin
         put_desc(dadr[k], 32'h600 + k * 64, 32'(lens[k]) | 32'h0000_A000, dadr[k+1]);
         expect_pkt(32'h600 + k * 64, lens[k], 99);
      end
      put_desc(32'h300, 32'h0, 32'h8000_0000, 32'h200);
      room_mode = 2;
      reg_write(2'd1, dadr[0]);
      reg_write(2'd0, 32'h1);
      wait_stop();
      exp_cnt += 6;
      cmp_stream("R5 random ring");
      reg_read(2'd1, v);
      chk(v == 32'h300, "R8 ring followed to end", v, 32'h300);
      reg_read(2'd2, v);
      chk(v == ((exp_cnt % 256) << 16 | 32'h3), "R7 count after random ring", v, (exp_cnt % 256) << 16 | 32'h3);

      // R9 bus error on second data word of second packet
      reg_write(2'd2, 32'h7);
      reg_write(2'd3, 32'h4);
      clear_logs();
      put_desc(32'h340, 32'h800, 32'd12, 32'h34C);
      put_desc(32'h34C, 32'h840, 32'd16, 32'h340);
      expect_pkt(32'h800, 12, 99);
      expect_pkt(32'h840, 16, 1);
      err_addr = 32'h844; err_on = 1'b1;
      room_mode = 1;
      reg_write(2'd1, 32'h340);
      reg_write(2'd0, 32'h1);
      wait_stop();
      exp_cnt += 1;
      cmp_stream("R9 error run");
      reg_read(2'd2, v);
      chk(v == ((exp_cnt % 256) << 16 | 32'h5), "R9 status after bus error", v, (exp_cnt % 256) << 16 | 32'h5);
      chk(mem[32'h350/4] == 32'd16, "R9 no write-back after error", mem[32'h350/4], 32'd16);
      repeat (2) @(negedge clk);
      chk(irq == 1'b1, "R10 bus error irq", irq, 1);
      base_l = lcnt;
      repeat (20) @(negedge clk);
      chk(lcnt == base_l, "R12 no access after error", lcnt, base_l);
      err_on = 1'b0;

      // R7 counter wrap
      reg_write(2'd2, 32'h7);
      room_mode = 2;
      base_l = 0;
      for (int r = 0; r < 64; r++) begin
         clear_logs();
         for (int k = 0; k < 4; k++)
            put_desc(32'h380 + k * 12, 32'hA00 + k * 16, 32'd4, 32'h380 + ((k + 1) % 4) * 12);
         reg_write(2'd1, 32'h380);
         reg_write(2'd0, 32'h1);
         wait_stop();
         exp_cnt += 4;
         if (fcnt != 4) base_l++;
         if (r == 61) begin
            reg_read(2'd2, v);
            chk(v[23:16] == 8'(exp_cnt % 256), "R7 counter wrapped past 255", v[23:16], exp_cnt % 256);
         end
      end
      chk(base_l == 0, "R5 four words per wrap round", base_l, 0);
      reg_read(2'd2, v);
      chk(v[23:16] == 8'(exp_cnt % 256), "R7 final counter", v[23:16], exp_cnt % 256);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule